// File: doc/BRIEF.md
# Video memory row-to-serial transfer unit

This block models the transfer path of a dual-port video memory. A transfer cycle starts when the row strobe falls. At that edge the unit samples the transfer gate, the write enable and the function select, and it captures a row address. The first fall of either column strobe then captures a tap address, which names the serial position where output begins. When the transfer gate rises while the row strobe is still low, the unit commits the selected row to a serial register that holds one word for every column. Serial output then runs from the tap, and each rising edge of the serial clock steps the read position by one.

The unit supports two transfer kinds. A full transfer overwrites the whole serial register and moves the read position to the tap. A split transfer refills only the half that is not being read, so output can continue without a gap, and it raises a status flag. The backing array holds a fixed computed pattern, so a bench can predict every word. The row count, column count, address width and word width are all parameters. Every pin is sampled on a single system clock, and edges are found by comparing each pin with its value one clock earlier.

Top module: `vxfer_unit`

## Requirements
- R1: A row-strobe fall starts a transfer only if `xgate_n` is 0 and `wr_en_n` is 1 at that edge. Any other combination leaves the serial register, the read position and `split_loaded` unchanged, even if later column-strobe and gate edges occur.
- R2: `fsel` is sampled at the row-strobe fall. A value of 0 selects a full transfer and a value of 1 selects a split transfer.
- R3: The row is selected by the low log2(ROWS) bits of `addr` at the row-strobe fall. Higher address bits are ignored.
- R4: The tap is taken from the low log2(COLS) bits of `addr` at the first clock where a column strobe reads low. A column strobe reads low when `cstb_lo_n` or `cstb_hi_n` is 0. Later column-strobe falls in the same cycle do not change the tap.
- R5: A rising `xgate_n` commits the transfer if three conditions hold: `rstb_n` is low, a transfer is pending, and a tap has been captured. If no tap has been captured, the transfer is dropped. A full commit writes all COLS words of the row and sets the read position to the tap.
- R6: `ser_data` always shows the word at the read position. Each rising `ser_clk` adds one to the read position, and the position wraps from COLS-1 to 0. If a full commit happens in the same clock, the read position goes to the tap instead.
- R7: A split commit writes only the columns whose top index bit differs from the top bit of the read position. It leaves the read position unchanged and sets `split_loaded`. A later full commit clears `split_loaded`.
- R8: After reset, every serial word is 0, the read position is 0 and `split_loaded` is 0.
- R9: The array word at row r and column c equals SEED XOR ((r mod 256) shifted left by 8) XOR (c mod 256), truncated to DW bits.
- R10: A row-strobe rise ends a pending transfer. A gate rise that comes after it commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rstb_n | input | 1 | Row strobe, active low |
| cstb_lo_n | input | 1 | Lower-byte column strobe, active low |
| cstb_hi_n | input | 1 | Upper-byte column strobe, active low |
| xgate_n | input | 1 | Transfer gate; low at the row-strobe fall requests a transfer, and its rise commits it |
| wr_en_n | input | 1 | Write enable, active low; must be high for a transfer |
| fsel | input | 1 | Function select: 0 for full, 1 for split |
| addr | input | ADDR_W | Row address at the row-strobe fall, tap address at the column-strobe fall |
| ser_clk | input | 1 | Serial clock; each rising edge advances the read position |
| ser_data | output | DW | Serial word at the read position |
| split_loaded | output | 1 | Set by a split commit, cleared by a full commit |

## Verification
The bench builds the unit with a 16-row, 16-column array and a 9-bit address. This keeps the serial register small enough to compare word by word against a bench-side model. The 16-column size lets a short shift run cross the half boundary and the wrap point, which exposes the split refill of the idle half. The 9-bit address carries upper bits that must be ignored. The address and the shift counts are chosen so that early, late and same-clock gate rises all land within a few clocks of the serial steps.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;

   // Fixed array content: seed, row and column are mixed into one word.
   function automatic logic [31:0] cell_word(input logic [31:0] seed,
                                             input int unsigned row,
                                             input int unsigned col);
      logic [31:0] r_part;
      logic [31:0] c_part;
      r_part = 32'((row & 32'd255) << 8);
      c_part = 32'(col & 32'd255);
      return seed ^ r_part ^ c_part;
   endfunction

   typedef enum logic [1:0] {
      XK_NONE  = 2'd0,
      XK_FULL  = 2'd1,
      XK_SPLIT = 2'd2
   } xfer_kind_t;

endpackage

// File: rtl/vxfer_ctl.sv
module vxfer_ctl #(
   parameter int ADDR_W = 9,
   parameter int RAW    = 4,
   parameter int CAW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rstb_n,
   input  logic              cstb_lo_n,
   input  logic              cstb_hi_n,
   input  logic              xgate_n,
   input  logic              wr_en_n,
   input  logic              fsel,
   input  logic [ADDR_W-1:0] addr,
   output logic              load_full,
   output logic              load_split,
   output logic [RAW-1:0]    row_sel,
   output logic [CAW-1:0]    tap_sel
);
   import vxfer_pkg::*;

   localparam int MW = (RAW > CAW) ? RAW : CAW;

   if (ADDR_W < MW) begin : g_bad_addr
      $error("vxfer_ctl: ADDR_W too narrow for row or tap index");
   end

   if (ADDR_W > MW) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:MW];
   end

   logic       rstb_q, xg_q, cs_q;
   logic       cs_low, rstb_fall, rstb_rise, cs_fall, xg_rise;
   logic       code_ok, commit;
   logic       pending, tap_ok;
   xfer_kind_t kind_r;
   logic [RAW-1:0] row_r;
   logic [CAW-1:0] tap_r;

   assign cs_low    = ~(cstb_lo_n & cstb_hi_n);
   assign rstb_fall = rstb_q & ~rstb_n;
   assign rstb_rise = ~rstb_q & rstb_n;
   assign cs_fall   = cs_low & ~cs_q;
   assign xg_rise   = ~xg_q & xgate_n;
   assign code_ok   = ~xgate_n & wr_en_n;
   assign commit    = pending & tap_ok & xg_rise & ~rstb_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rstb_q <= 1'b1;
         xg_q   <= 1'b1;
         cs_q   <= 1'b0;
      end else begin
         rstb_q <= rstb_n;
         xg_q   <= xgate_n;
         cs_q   <= cs_low;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         tap_ok  <= 1'b0;
         kind_r  <= XK_NONE;
         row_r   <= '0;
         tap_r   <= '0;
      end else if (rstb_fall) begin
         pending <= code_ok;
         tap_ok  <= 1'b0;
         if (code_ok) begin
            kind_r <= fsel ? XK_SPLIT : XK_FULL;
            row_r  <= addr[RAW-1:0];
         end else begin
            kind_r <= XK_NONE;
         end
      end else if (rstb_rise || commit) begin
         pending <= 1'b0;
         tap_ok  <= 1'b0;
      end else if (pending && cs_fall && !tap_ok && !rstb_n) begin
         tap_r  <= addr[CAW-1:0];
         tap_ok <= 1'b1;
      end
   end

   assign load_full  = commit & (kind_r == XK_FULL);
   assign load_split = commit & (kind_r == XK_SPLIT);
   assign row_sel    = row_r;
   assign tap_sel    = tap_r;

   // R1: a fall without the transfer code never leaves a cycle pending
   a_r1_no_code_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (rstb_fall && !code_ok) |=> !pending);

   // R2: the latched kind follows the function select at the fall
   a_r2_kind_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (rstb_fall && code_ok) |=>
         (pending && ((kind_r == XK_SPLIT) == $past(fsel))));

   // R10: once the row strobe rises, nothing stays pending
   a_r10_rise_ends: assert property (@(posedge clk) disable iff (!rst_n)
      rstb_rise |=> !pending);

endmodule

// File: rtl/vxfer_rowsrc.sv
module vxfer_rowsrc #(
   parameter int          ROWS = 16,
   parameter int          COLS = 16,
   parameter int          DW   = 16,
   parameter int unsigned SEED = 32'h0000A5C3,
   localparam int         RAW  = $clog2(ROWS)
) (
   input  logic [RAW-1:0]           row_sel,
   output logic [COLS-1:0][DW-1:0]  row_words
);
   import vxfer_pkg::*;

   if (DW > 32) begin : g_bad_dw
      $error("vxfer_rowsrc: DW above 32 not supported");
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [31:0] full_word;
      always_comb begin
         full_word = cell_word(SEED, int'(unsigned'(row_sel)), c);
      end
      assign row_words[c] = full_word[DW-1:0];
      if (DW < 32) begin : g_trim
         logic unused_top;
         assign unused_top = ^full_word[31:DW];
      end
   end

endmodule

// File: rtl/vxfer_sreg.sv
module vxfer_sreg #(
   parameter int COLS = 16,
   parameter int DW   = 16,
   localparam int CAW = $clog2(COLS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ser_clk,
   input  logic                     load_full,
   input  logic                     load_split,
   input  logic [CAW-1:0]           tap_sel,
   input  logic [COLS-1:0][DW-1:0]  row_words,
   output logic [DW-1:0]            ser_data,
   output logic                     split_loaded
);

   logic [DW-1:0]  sam [COLS];
   logic [CAW-1:0] ptr;
   logic           sclk_q, step;

   assign step = ser_clk & ~sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= ser_clk;
   end

   for (genvar c = 0; c < COLS; c++) begin : g_word
      localparam logic HALF = 1'((c >> (CAW - 1)) & 1);
      logic take;
      assign take = load_full | (load_split & (ptr[CAW-1] != HALF));
      always_ff @(posedge clk) begin
         if (!rst_n)    sam[c] <= '0;
         else if (take) sam[c] <= row_words[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         ptr <= '0;
      else if (load_full) ptr <= tap_sel;
      else if (step)      ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          split_loaded <= 1'b0;
      else if (load_full)  split_loaded <= 1'b0;
      else if (load_split) split_loaded <= 1'b1;
   end

   assign ser_data = sam[ptr];

   // R5: a full commit places the read position on the tap
   a_r5_full_to_tap: assert property (@(posedge clk) disable iff (!rst_n)
      load_full |=> (ptr == $past(tap_sel)));

   // R6: a serial step moves exactly one position, wrapping
   a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_full) |=> (ptr == CAW'($past(ptr) + 1'b1)));

   // R7: a split keeps the word under the read position
   a_r7_split_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
      (load_split && !step) |=>
         (ptr == $past(ptr) && ser_data == $past(ser_data) && split_loaded));

   // R6: no step and no commit keeps position and output
   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load_full && !load_split) |=> ($stable(ptr) && $stable(ser_data)));

endmodule

// File: rtl/vxfer_unit.sv
module vxfer_unit #(
   parameter int          ROWS   = 16,
   parameter int          COLS   = 16,
   parameter int          ADDR_W = 9,
   parameter int          DW     = 16,
   parameter int unsigned SEED   = 32'h0000A5C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rstb_n,
   input  logic              cstb_lo_n,
   input  logic              cstb_hi_n,
   input  logic              xgate_n,
   input  logic              wr_en_n,
   input  logic              fsel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ser_clk,
   output logic [DW-1:0]     ser_data,
   output logic              split_loaded
);

   localparam int RAW = $clog2(ROWS);
   localparam int CAW = $clog2(COLS);

   if (ROWS < 2 || (1 << RAW) != ROWS) begin : g_bad_rows
      $error("vxfer_unit: ROWS must be a power of two of at least 2");
   end
   if (COLS < 2 || (1 << CAW) != COLS) begin : g_bad_cols
      $error("vxfer_unit: COLS must be a power of two of at least 2");
   end

   logic                    load_full, load_split;
   logic [RAW-1:0]          row_sel;
   logic [CAW-1:0]          tap_sel;
   logic [COLS-1:0][DW-1:0] row_words;

   vxfer_ctl #(.ADDR_W(ADDR_W), .RAW(RAW), .CAW(CAW)) i_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rstb_n    (rstb_n),
      .cstb_lo_n (cstb_lo_n),
      .cstb_hi_n (cstb_hi_n),
      .xgate_n   (xgate_n),
      .wr_en_n   (wr_en_n),
      .fsel      (fsel),
      .addr      (addr),
      .load_full (load_full),
      .load_split(load_split),
      .row_sel   (row_sel),
      .tap_sel   (tap_sel)
   );

   vxfer_rowsrc #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .SEED(SEED)) i_rows (
      .row_sel  (row_sel),
      .row_words(row_words)
   );

   vxfer_sreg #(.COLS(COLS), .DW(DW)) i_sreg (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_clk     (ser_clk),
      .load_full   (load_full),
      .load_split  (load_split),
      .tap_sel     (tap_sel),
      .row_words   (row_words),
      .ser_data    (ser_data),
      .split_loaded(split_loaded)
   );

   // R5: full and split commits never fire together
   a_r5_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_full, load_split}));

endmodule

// File: tb/test_vxfer_unit.sv
module test_vxfer_unit;

   localparam int          ROWS   = 16;
   localparam int          COLS   = 16;
   localparam int          ADDR_W = 9;
   localparam int          DW     = 16;
   localparam int unsigned SEED   = 32'h0000A5C3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rstb_n = 1'b1, cstb_lo_n = 1'b1, cstb_hi_n = 1'b1;
   logic xgate_n = 1'b1, wr_en_n = 1'b1, fsel = 1'b0, ser_clk = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DW-1:0] ser_data;
   logic split_loaded;

   always #4 clk = ~clk;

   vxfer_unit #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .DW(DW), .SEED(SEED))
   i_vxfer_unit (
      .clk(clk), .rst_n(rst_n), .rstb_n(rstb_n), .cstb_lo_n(cstb_lo_n),
      .cstb_hi_n(cstb_hi_n), .xgate_n(xgate_n), .wr_en_n(wr_en_n), .fsel(fsel),
      .addr(addr), .ser_clk(ser_clk), .ser_data(ser_data),
      .split_loaded(split_loaded)
   );

   typedef struct packed {
      logic       dsel;
      logic [8:0] row;
      logic [8:0] tap;
      logic [1:0] mode;   // 0 early, 1 late, 2 same-clock serial step, 3 second strobe fall
      logic       upper;
      logic [4:0] nsh;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 9'd3,    9'd5,    2'd0, 1'b0, 5'd4},
      '{1'b0, 9'd7,    9'd14,   2'd1, 1'b1, 5'd5},
      '{1'b0, 9'd12,   9'd0,    2'd2, 1'b0, 5'd3},
      '{1'b1, 9'd9,    9'd2,    2'd0, 1'b0, 5'd8},
      '{1'b1, 9'd2,    9'd6,    2'd1, 1'b1, 5'd8},
      '{1'b0, 9'd15,   9'd8,    2'd0, 1'b1, 5'd3},
      '{1'b0, 9'h1F5,  9'h1E3,  2'd3, 1'b0, 5'd2}
   };

   int nchk = 0;
   int nbad = 0;
   logic [DW-1:0] ref_sam [COLS];
   int ref_ptr = 0;
   logic ref_flag = 1'b0;

   function automatic logic [DW-1:0] pat(input int r, input int c);
      int unsigned w;
      w = SEED ^ ((r & 255) << 8) ^ (c & 255);
      return w[DW-1:0];
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic ref_reset();
      for (int c = 0; c < COLS; c++) ref_sam[c] = '0;
      ref_ptr = 0;
      ref_flag = 1'b0;
   endtask

   task automatic ref_commit(input logic d, input int r, input int t);
      if (!d) begin
         for (int c = 0; c < COLS; c++) ref_sam[c] = pat(r, c);
         ref_ptr = t;
         ref_flag = 1'b0;
      end else begin
         for (int c = 0; c < COLS; c++)
            if ((c >= COLS / 2) != (ref_ptr >= COLS / 2)) ref_sam[c] = pat(r, c);
         ref_flag = 1'b1;
      end
   endtask

   // R6: step the serial clock n times, checking each word
   task automatic shift_check(input int n, input string tag);
      check({tag, " R6 word at position"}, int'(ser_data), int'(ref_sam[ref_ptr]));
      for (int i = 0; i < n; i++) begin
         ser_clk = 1'b1;
         tick();
         ref_ptr = (ref_ptr + 1) % COLS;
         check({tag, " R6 shifted word"}, int'(ser_data), int'(ref_sam[ref_ptr]));
         ser_clk = 1'b0;
         tick();
      end
   endtask

   task automatic do_xfer(input vec_t v);
      int r, t;
      r = int'(v.row) % ROWS;
      t = int'(v.tap) % COLS;
      tick(); xgate_n = 1'b0; wr_en_n = 1'b1; fsel = v.dsel; addr = v.row;
      tick(); rstb_n = 1'b0;
      tick(); addr = v.tap; if (v.upper) cstb_hi_n = 1'b0; else cstb_lo_n = 1'b0;
      if (v.mode == 2'd3) begin
         tick(); cstb_lo_n = 1'b1; cstb_hi_n = 1'b1; addr = ~v.tap;
         tick(); cstb_lo_n = 1'b0;
      end
      if (v.mode == 2'd1) repeat (3) tick();
      tick(); xgate_n = 1'b1; if (v.mode == 2'd2) ser_clk = 1'b1;
      tick(); ser_clk = 1'b0;
      ref_commit(v.dsel, r, t);
      rstb_n = 1'b1; cstb_lo_n = 1'b1; cstb_hi_n = 1'b1;
      tick();
   endtask

   // a cycle that must not commit anything
   task automatic dead_cycle(input logic xg, input logic we, input logic do_cs,
                             input logic rise_first);
      tick(); xgate_n = xg; wr_en_n = we; fsel = 1'b0; addr = 9'd4;
      tick(); rstb_n = 1'b0;
      tick(); addr = 9'd1; if (do_cs) cstb_lo_n = 1'b0;
      tick(); if (rise_first) rstb_n = 1'b1;
      tick(); xgate_n = 1'b1;
      tick(); rstb_n = 1'b1; cstb_lo_n = 1'b1; wr_en_n = 1'b1;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      ref_reset();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R8: reset state
      check("R8 data after reset", int'(ser_data), 0);
      check("R8 flag after reset", int'(split_loaded), 0);
      shift_check(1, "R8");

      // R2 R3 R4 R5 R7 R9: table walk
      for (int i = 0; i < NV; i++) begin
         do_xfer(VECS[i]);
         check("R7 R2 split flag", int'(split_loaded), int'(ref_flag));
         check("R9 R5 R3 word at tap", int'(ser_data), int'(ref_sam[ref_ptr]));
         shift_check(int'(VECS[i].nsh), "R4 R7");
      end

      // R1: normal-cycle code (gate high) ignored
      dead_cycle(1'b1, 1'b1, 1'b1, 1'b0);
      check("R1 gate high no change", int'(ser_data), int'(ref_sam[ref_ptr]));
      check("R1 gate high flag", int'(split_loaded), int'(ref_flag));
      shift_check(2, "R1");
      // R1: write enable low ignored
      dead_cycle(1'b0, 1'b0, 1'b1, 1'b0);
      check("R1 write low no change", int'(ser_data), int'(ref_sam[ref_ptr]));
      shift_check(2, "R1");
      // R5: no column strobe, transfer dropped
      dead_cycle(1'b0, 1'b1, 1'b0, 1'b0);
      check("R5 no tap no change", int'(ser_data), int'(ref_sam[ref_ptr]));
      shift_check(2, "R5");
      // R10: row strobe rises before the gate
      dead_cycle(1'b0, 1'b1, 1'b1, 1'b1);
      check("R10 late gate no change", int'(ser_data), int'(ref_sam[ref_ptr]));
      shift_check(2, "R10");

      // R8: reset after activity
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      ref_reset();
      tick();
      check("R8 data after second reset", int'(ser_data), 0);
      check("R8 flag after second reset", int'(split_loaded), 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

endmodule